// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects interrupt requests for a small microcontroller core from five hardware sources. Two are active-low external pins. Two are timer overflow pulses. The fifth is a serial port whose transmit-done and receive-done flags are OR-ed into one request. The block holds the request flags, the per-source enables, a global enable and a per-source priority bit. It picks one winning request and offers it to the core as a request line with a vector address.

The core completes the handshake with a one-cycle acknowledge, and later with a one-cycle return-from-interrupt. The controller keeps track of which priority levels are in service. A high-priority request can interrupt low-priority service once. Nothing interrupts high-priority service.

Software reaches four 8-bit registers through a plain write strobe and a combinational read port:

| Address | Register |
|---|---|
| 0 | event |
| 1 | serial |
| 2 | enable |
| 3 | priority |

The timers and the serial unit sit outside the block and appear only as request pulses.

Top module: `nest_intc`

## Requirements
- R1: After reset, all four registers read 0x00, `irq_req` is low, and both external pins count as released (high).
- R2: A source can raise `irq_req` only if two bits are both set: its own enable bit and the global enable bit (bit 7 of register 2). Register 2 holds the enable bits at bits 0..4, in source order ext0, tmr0, ext1, tmr1, serial.
- R3: Among requests of the same priority level, the winner follows a fixed order: ext0, then tmr0, then ext1, then tmr1, then serial. Source index i gives vector 0x0003 + 8*i.
- R4: Any pending high-priority request beats every low-priority request, whatever the source order. A source is high priority when its bit in register 3 (bits 0..4, source order) is set.
- R5: An acknowledge (`irq_ack` while `irq_req` is high) marks the winner's level as in service. While low is in service, only high requests are offered. While high is in service, nothing is offered.
- R6: `irq_reti` clears the high in-service mark if it is set, and otherwise clears the low mark.
- R7: An external pin is in edge mode when its mode bit is set: bit 0 of register 0 for ext0, bit 2 for ext1. In edge mode, a high-to-low step of the pin, seen in two consecutive samples, sets the pin's flag. The flag then stays set after the pin rises, and clears when that source is acknowledged. The ext0 flag is bit 1 of register 0 and the ext1 flag is bit 3.
- R8: In level mode, the external flag is the inverse of the pin, sampled once a cycle. Acknowledge does not clear it.
- R9: A timer overflow pulse sets the timer's flag (register 0, bit 5 for tmr0, bit 7 for tmr1). Acknowledge of that timer clears the flag.
- R10: The serial flags are tx (register 1 bit 0) and rx (register 1 bit 1). They are set by their done pulses. Either flag raises the serial request, and acknowledge never clears them.
- R11: A software write to register 0 or 1 loads the timer, serial and edge-mode flags. Writing 0 withdraws a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ext0_n | input | 1 | External request pin 0, active low |
| ext1_n | input | 1 | External request pin 1, active low |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_tx_done | input | 1 | Serial transmit-done pulse |
| ser_rx_done | input | 1 | Serial receive-done pulse |
| irq_req | output | 1 | A request is offered to the core |
| irq_vec | output | ADDR_W | Vector address of the offered request |
| irq_ack | input | 1 | Core takes the offered request |
| irq_reti | input | 1 | Core returns from the current service routine |

## Verification
The hardest state to reach is both levels in service at once, followed by two returns in a row. The first return must drop only the high mark. The second return must drop the low mark and let a pending low request reappear. The stimulus gets there in steps. It first takes a low-priority timer request. It then pulses the other timer, which has high priority, and acknowledges the nested request. Next it arms a low-priority serial flag, which must stay hidden. Finally it issues the two returns, checking the request line after each one.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;
   localparam int NSRC = 5;

   typedef enum logic [1:0] {
      RA_EVT = 2'd0,
      RA_SER = 2'd1,
      RA_ENA = 2'd2,
      RA_PRI = 2'd3
   } reg_addr_e;

   localparam int EVT_E0_MODE = 0;
   localparam int EVT_E0_FLAG = 1;
   localparam int EVT_E1_MODE = 2;
   localparam int EVT_E1_FLAG = 3;
   localparam int EVT_T0_FLAG = 5;
   localparam int EVT_T1_FLAG = 7;
   localparam int ENA_GLOBAL  = 7;
endpackage

// File: rtl/nest_intc_extin.sv
module nest_intc_extin #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic sw_we,
   input  logic sw_flag,
   input  logic ack_clr,
   output logic flag
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic pin_s;
   logic pin_q;
   logic fell;

   if (SYNC_STAGES == 0) begin : g_direct
      assign pin_s = pin_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], pin_n};
      end
      assign pin_s = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b1;
      else        pin_q <= pin_s;
   end

   assign fell = pin_q & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (!edge_mode) flag <= ~pin_s;
      else if (fell)      flag <= 1'b1;
      else if (ack_clr)   flag <= 1'b0;
      else if (sw_we)     flag <= sw_flag;
   end

   AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && ack_clr && !fell && !sw_we) |=> !flag); // R7
endmodule

// File: rtl/nest_intc_pick.sv
module nest_intc_pick #(
   parameter int N = 5
) (
   input  logic [N-1:0]         req,
   output logic [N-1:0]         grant,
   output logic [$clog2(N)-1:0] idx,
   output logic                 any
);
   localparam int IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_grant
      if (i == 0) begin : g_first
         assign grant[i] = req[i];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (grant[i]) idx = IW'(i);
      end
   end

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R3
   end
endmodule

// File: rtl/nest_intc_track.sv
module nest_intc_track (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_hi,
   input  logic reti,
   output logic isr_lo,
   output logic isr_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_lo <= 1'b0;
         isr_hi <= 1'b0;
      end else if (take) begin
         if (take_hi) isr_hi <= 1'b1;
         else         isr_lo <= 1'b1;
      end else if (reti) begin
         if (isr_hi) isr_hi <= 1'b0;
         else        isr_lo <= 1'b0;
      end
   end

   AST_RETI_POPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && isr_hi && !take) |=> (!isr_hi && $stable(isr_lo))); // R6
   AST_NO_TAKE_IN_HI: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi |-> !take); // R5
endmodule

// File: rtl/nest_intc.sv
module nest_intc
   import nest_intc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STEP    = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              ext0_n,
   input  logic              ext1_n,
   input  logic              tmr0_ovf,
   input  logic              tmr1_ovf,
   input  logic              ser_tx_done,
   input  logic              ser_rx_done,
   output logic              irq_req,
   output logic [ADDR_W-1:0] irq_vec,
   input  logic              irq_ack,
   input  logic              irq_reti
);
   localparam int IW = $clog2(NSRC);

   if (ADDR_W < 8 || ADDR_W > 24) begin : g_bad_w
      $error("ADDR_W must lie in 8..24");
   end
   if (VEC_STEP < 1 || VEC_BASE < 0 ||
       VEC_BASE + (NSRC - 1) * VEC_STEP >= (1 << ADDR_W)) begin : g_bad_vec
      $error("vector table does not fit in ADDR_W bits");
   end

   logic [1:0]      mode_q;
   logic [1:0]      ext_flag;
   logic            t0f_q, t1f_q, txf_q, rxf_q;
   logic [NSRC-1:0] ie_q, ip_q;
   logic            ea_q;
   logic            evt_we, ser_we;
   logic [NSRC-1:0] src_flag, req, hi_req, lo_req;
   logic [NSRC-1:0] hi_grant, lo_grant, sel_grant, clr;
   logic [IW-1:0]   hi_idx, lo_idx, sel_idx;
   logic            hi_any, lo_any, sel_hi, sel_lo, take;
   logic            isr_lo, isr_hi;
   logic            unused_wbits;

   assign evt_we = reg_we && (reg_addr == RA_EVT);
   assign ser_we = reg_we && (reg_addr == RA_SER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ie_q   <= '0;
         ip_q   <= '0;
         ea_q   <= 1'b0;
      end else if (reg_we) begin
         case (reg_addr)
            RA_EVT: mode_q <= {reg_wdata[EVT_E1_MODE], reg_wdata[EVT_E0_MODE]};
            RA_ENA: begin
               ie_q <= reg_wdata[NSRC-1:0];
               ea_q <= reg_wdata[ENA_GLOBAL];
            end
            RA_PRI: ip_q <= reg_wdata[NSRC-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t0f_q <= 1'b0;
         t1f_q <= 1'b0;
         txf_q <= 1'b0;
         rxf_q <= 1'b0;
      end else begin
         if (tmr0_ovf)    t0f_q <= 1'b1;
         else if (clr[1]) t0f_q <= 1'b0;
         else if (evt_we) t0f_q <= reg_wdata[EVT_T0_FLAG];

         if (tmr1_ovf)    t1f_q <= 1'b1;
         else if (clr[3]) t1f_q <= 1'b0;
         else if (evt_we) t1f_q <= reg_wdata[EVT_T1_FLAG];

         if (ser_tx_done) txf_q <= 1'b1;
         else if (ser_we) txf_q <= reg_wdata[0];

         if (ser_rx_done) rxf_q <= 1'b1;
         else if (ser_we) rxf_q <= reg_wdata[1];
      end
   end

   logic [1:0] pins_n;
   assign pins_n = {ext1_n, ext0_n};

   for (genvar k = 0; k < 2; k++) begin : g_ext
      nest_intc_extin #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_n    (pins_n[k]),
         .edge_mode(mode_q[k]),
         .sw_we    (evt_we),
         .sw_flag  (reg_wdata[2*k+1]),
         .ack_clr  (clr[2*k]),
         .flag     (ext_flag[k])
      );
   end

   assign src_flag = {txf_q | rxf_q, t1f_q, ext_flag[1], t0f_q, ext_flag[0]};
   assign req      = src_flag & ie_q & {NSRC{ea_q}};
   assign hi_req   = req & ip_q;
   assign lo_req   = req & ~ip_q;

   nest_intc_pick #(.N(NSRC)) u_pick_hi (
      .req(hi_req), .grant(hi_grant), .idx(hi_idx), .any(hi_any));
   nest_intc_pick #(.N(NSRC)) u_pick_lo (
      .req(lo_req), .grant(lo_grant), .idx(lo_idx), .any(lo_any));

   assign sel_hi    = hi_any && !isr_hi;
   assign sel_lo    = !hi_any && lo_any && !isr_lo && !isr_hi;
   assign irq_req   = sel_hi || sel_lo;
   assign sel_grant = sel_hi ? hi_grant : (sel_lo ? lo_grant : '0);
   assign sel_idx   = sel_hi ? hi_idx : lo_idx;
   assign irq_vec   = ADDR_W'(VEC_BASE + int'(sel_idx) * VEC_STEP);
   assign take      = irq_ack && irq_req;
   assign clr       = take ? sel_grant : '0;

   nest_intc_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .take_hi(sel_hi),
      .reti   (irq_reti),
      .isr_lo (isr_lo),
      .isr_hi (isr_hi)
   );

   always_comb begin
      case (reg_addr)
         RA_EVT:  reg_rdata = {t1f_q, 1'b0, t0f_q, 1'b0,
                               ext_flag[1], mode_q[1], ext_flag[0], mode_q[0]};
         RA_SER:  reg_rdata = {6'b0, rxf_q, txf_q};
         RA_ENA:  reg_rdata = {ea_q, 2'b0, ie_q};
         default: reg_rdata = {3'b0, ip_q};
      endcase
   end

   assign unused_wbits = ^{reg_wdata[6:5]};

   AST_GATED_BY_EA: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ea_q); // R2
   AST_NO_REQ_IN_HI: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi |-> !irq_req); // R5
endmodule

// File: tb/sim_nest_intc.sv
module sim_nest_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        ext0_n = 1'b1, ext1_n = 1'b1;
   logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
   logic        ser_tx_done = 1'b0, ser_rx_done = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic        irq_ack = 1'b0, irq_reti = 1'b0;
   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   nest_intc u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ext0_n(ext0_n), .ext1_n(ext1_n), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
      .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti)
   );

   task automatic check(input string req, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic reti();
      @(negedge clk); irq_reti = 1'b1;
      @(negedge clk); irq_reti = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 irq_req", int'(irq_req), 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         check("R1 register", int'(d), 0);
      end
   endtask

   task automatic t_gating();
      logic [7:0] d;
      @(negedge clk); tmr0_ovf = 1'b1;
      @(negedge clk); tmr0_ovf = 1'b0;
      rd(2'd0, d);
      check("R9 tmr0 flag set", int'(d), 8'h20);
      wr(2'd2, 8'h02);
      check("R2 no global enable", int'(irq_req), 0);
      wr(2'd2, 8'h82);
      check("R2 enabled req", int'(irq_req), 1);
      check("R3 tmr0 vector", int'(irq_vec), 16'h000B);
      wr(2'd2, 8'h80);
      check("R2 source disabled", int'(irq_req), 0);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_poll();
      logic [7:0] d;
      wr(2'd2, 8'h9F);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'hA0);
      check("R3 tmr0 over tmr1", int'(irq_vec), 16'h000B);
      wr(2'd0, 8'h80);
      check("R3 tmr1 alone", int'(irq_vec), 16'h001B);
      wr(2'd0, 8'h00);
      check("R11 cleared by write", int'(irq_req), 0);
      @(negedge clk); ser_rx_done = 1'b1;
      @(negedge clk); ser_rx_done = 1'b0;
      rd(2'd1, d);
      check("R10 rx flag", int'(d), 8'h02);
      check("R10 serial vector", int'(irq_vec), 16'h0023);
      wr(2'd1, 8'h00);
      check("R11 serial cleared", int'(irq_req), 0);
   endtask

   task automatic t_prio();
      wr(2'd2, 8'h8A);
      wr(2'd3, 8'h08);
      wr(2'd0, 8'hA0);
      check("R4 high beats order", int'(irq_vec), 16'h001B);
   endtask

   task automatic t_nest();
      logic [7:0] d;
      ack();
      check("R5 high in service blocks", int'(irq_req), 0);
      rd(2'd0, d);
      check("R9 ack clears tmr1", int'(d), 8'h20);
      reti();
      check("R6 low request back", int'(irq_req), 1);
      check("R6 low vector", int'(irq_vec), 16'h000B);
      ack();
      check("R5 low in service", int'(irq_req), 0);
      @(negedge clk); tmr1_ovf = 1'b1;
      @(negedge clk); tmr1_ovf = 1'b0;
      check("R5 high nests", int'(irq_req), 1);
      check("R5 nested vector", int'(irq_vec), 16'h001B);
      ack();
      wr(2'd2, 8'h9A);
      wr(2'd1, 8'h01);
      check("R5 both levels busy", int'(irq_req), 0);
      reti();
      check("R6 first reti leaves low", int'(irq_req), 0);
      reti();
      check("R6 second reti frees low", int'(irq_req), 1);
      check("R10 tx vector", int'(irq_vec), 16'h0023);
      ack();
      rd(2'd1, d);
      check("R10 ack keeps serial", int'(d), 8'h01);
      reti();
      check("R10 serial still pending", int'(irq_req), 1);
      wr(2'd1, 8'h00);
      check("R11 serial write clears", int'(irq_req), 0);
   endtask

   task automatic t_edge();
      logic [7:0] d;
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h81);
      wr(2'd3, 8'h00);
      @(negedge clk); ext0_n = 1'b0;
      @(negedge clk);
      check("R7 edge req", int'(irq_req), 1);
      check("R7 ext0 vector", int'(irq_vec), 16'h0003);
      ext0_n = 1'b1;
      @(negedge clk);
      check("R7 latched after rise", int'(irq_req), 1);
      rd(2'd0, d);
      check("R7 flag readback", int'(d), 8'h03);
      ack();
      rd(2'd0, d);
      check("R7 ack clears flag", int'(d), 8'h01);
      reti();
      check("R7 no request left", int'(irq_req), 0);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_level();
      logic [7:0] d;
      wr(2'd2, 8'h84);
      @(negedge clk); ext1_n = 1'b0;
      @(negedge clk);
      check("R8 level req", int'(irq_req), 1);
      check("R8 ext1 vector", int'(irq_vec), 16'h0013);
      ack();
      rd(2'd0, d);
      check("R8 ack keeps level flag", int'(d), 8'h08);
      reti();
      check("R8 still requesting", int'(irq_req), 1);
      ext1_n = 1'b1;
      @(negedge clk);
      check("R8 follows pin", int'(irq_req), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gating();
      t_poll();
      t_prio();
      t_nest();
      t_edge();
      t_level();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule